// File: doc/BRIEF.md
# Platform System Controller

A memory-mapped block of 32-bit system words on a simple request bus. It gives software three identity words and two free-running elapsed-time counters, fed by 24 MHz and 100 MHz tick enables. It also holds a lock word, a flags word with its own clear location, and a set of constant oscillator, LCD and flash words that cannot be written.

A configuration mailbox answers oscillator frequency queries. The host writes a packed request word to the mailbox control location. When the request is a qualifying read, the mailbox data word is loaded with the frequency of the addressed clock. The host then reads that word back. The status location always reports the mailbox as done, and the control location always reports it as idle.

Each access is one request cycle with a byte address inside a 0xD4-byte window. A read returns its data one cycle later, marked by a valid strobe. A write takes effect at the clock edge that samples it.

Top module: `plat_sysctl`

## Requirements
- R1: An asynchronous active-low reset clears the lock, flags, mailbox data word, both counters and the read-valid strobe to 0.
- R2: A read request sampled at a clock edge drives `rvalid_o` high with its data after that edge, for one cycle. Write requests and idle cycles leave `rvalid_o` low.
- R3: Offset 0x00 reads the BOARD_ID parameter. Offsets 0x84 and 0x88 read PROC_ID0 and PROC_ID1.
- R4: These fixed words cannot be changed by writes: flash 0x4C = 0; LCD 0x50 = 0x00001F00; oscillators 0x0C, 0x10, 0x14, 0x18, 0x1C = 0x00012C5C, 0x00002CC0, 0x00002C75, 0x00020211, 0x00002C75.
- R5: Reads of unmapped offsets return 0. This includes offsets at or above 0xD4 and offsets that are not word-aligned. Writes to unmapped offsets change no state.
- R6: A write to the lock word at 0x20 keeps only write-data bits 15:0. Reads of 0x20 return them zero-extended.
- R7: A write to 0x30 loads all 32 flag bits. A write of any data to 0x34 clears the flags to 0.
- R8: The counters at 0x5C (24 MHz tick) and 0x60 (100 MHz tick) each add one per cycle in which their tick input is high, and wrap modulo 2^32.
- R9: The mailbox status word 0xA8 always reads 1, even after it is written. The mailbox control word 0xA4 always reads 0.
- R10: A write to 0xA4 is decoded as follows: start in bit 31, write flag in bit 30, controller in bits 29:26, function in bits 25:20, site in bits 17:16, position in bits 15:12, device in bits 11:0. Nothing happens unless start is 1 and the write flag is 0.
- R11: A started read request is served only when the controller is 0, the position is 0 and the function is 1. Otherwise the data word keeps its value.
- R12: A served request loads the data word from this table. Site 0: device 0 or 1 gives 25000000, device 2 gives 24000000. Site 1: devices 0 and 5 give 50000000, devices 4, 7 and 8 give 40000000, device 6 gives 35000000. Any other device at site 0 or 1 gives 0. Sites 2 and 3 keep the old value.
- R13: The mailbox data word at 0xA0 can be written directly by the host and reads back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset inside the window |
| wdata_i | input | 32 | Write data |
| tick24_i | input | 1 | Single-cycle 24 MHz tick enable |
| tick100_i | input | 1 | Single-cycle 100 MHz tick enable |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |

## Verification
The assertions take for granted a few things about the inputs:
- `we_i` and `addr_i` are meaningful only when `req_i` is high.
- The host never writes the mailbox data and control locations in the same cycle. The single shared address makes that impossible.
- Tick enables may arrive in any cycle.

The stimulus issues one access at a time, separated by idle cycles, with inputs changed only on the falling edge. It holds both ticks low while reading the counters, so each counter value is exact. Wrap-around of the 32-bit counters is covered only by the per-tick increment property, because reaching 2^32 ticks is out of reach of a short run.

// File: rtl/plat_sysctl_pkg.sv
package plat_sysctl_pkg;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NUM_OSC = 5;
  localparam int NUM_CNT = 2;
  localparam int LOCK_W = 16;

  localparam logic [AW-1:0] OFS_BOARD_ID  = 8'h00;
  localparam logic [AW-1:0] OFS_OSC_BASE  = 8'h0C;
  localparam logic [AW-1:0] OFS_LOCK      = 8'h20;
  localparam logic [AW-1:0] OFS_FLAGS     = 8'h30;
  localparam logic [AW-1:0] OFS_FLAGS_CLR = 8'h34;
  localparam logic [AW-1:0] OFS_FLASH     = 8'h4C;
  localparam logic [AW-1:0] OFS_LCD       = 8'h50;
  localparam logic [AW-1:0] OFS_CNT_BASE  = 8'h5C;
  localparam logic [AW-1:0] OFS_PROC_ID0  = 8'h84;
  localparam logic [AW-1:0] OFS_PROC_ID1  = 8'h88;
  localparam logic [AW-1:0] OFS_CFG_DATA  = 8'hA0;
  localparam logic [AW-1:0] OFS_CFG_CTRL  = 8'hA4;
  localparam logic [AW-1:0] OFS_CFG_STAT  = 8'hA8;

  localparam logic [DW-1:0] FLASH_WORD = 32'h0000_0000;
  localparam logic [DW-1:0] LCD_WORD   = 32'h0000_1F00;
  localparam logic [DW-1:0] OSC_WORDS [NUM_OSC] = '{
    32'h0001_2C5C, 32'h0000_2CC0, 32'h0000_2C75, 32'h0002_0211, 32'h0000_2C75
  };

  localparam logic [DW-1:0] HZ_24M = 32'd24_000_000;
  localparam logic [DW-1:0] HZ_25M = 32'd25_000_000;
  localparam logic [DW-1:0] HZ_35M = 32'd35_000_000;
  localparam logic [DW-1:0] HZ_40M = 32'd40_000_000;
  localparam logic [DW-1:0] HZ_50M = 32'd50_000_000;

  typedef struct packed {
    logic        start;
    logic        wr;
    logic [3:0]  ctl;
    logic [5:0]  fn;
    logic [1:0]  rsvd;
    logic [1:0]  site;
    logic [3:0]  pos;
    logic [11:0] dev;
  } cfg_req_t;

  // frequency for site 0/1; 0 for an unknown device
  function automatic logic [DW-1:0] clk_freq(input logic site1, input logic [11:0] dev);
    logic [DW-1:0] f;
    f = '0;
    if (!site1) begin
      case (dev)
        12'd0, 12'd1: f = HZ_25M;
        12'd2:        f = HZ_24M;
        default:      f = '0;
      endcase
    end else begin
      case (dev)
        12'd0, 12'd5:        f = HZ_50M;
        12'd4, 12'd7, 12'd8: f = HZ_40M;
        12'd6:               f = HZ_35M;
        default:             f = '0;
      endcase
    end
    return f;
  endfunction
endpackage

// File: rtl/plat_sysctl_tick_cnt.sv
module plat_sysctl_tick_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  // R8
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_o == W'($past(cnt_o) + 1'b1));
  // R8
  hold_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/plat_sysctl_cfg_mbox.sv
module plat_sysctl_cfg_mbox
  import plat_sysctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          data_we_i,
  input  logic          ctrl_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] data_o
);
  cfg_req_t req;
  logic     serve;

  assign req   = cfg_req_t'(wdata_i);
  // qualifying read to a known site
  assign serve = ctrl_we_i && req.start && !req.wr && (req.ctl == '0) &&
                 (req.pos == '0) && (req.fn == 6'd1) && !req.site[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_o <= '0;
    else if (data_we_i) data_o <= wdata_i;
    else if (serve)     data_o <= clk_freq(req.site[0], req.dev);
  end

  // R10
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !data_we_i && (!wdata_i[31] || wdata_i[30])) |=> $stable(data_o));
  // R12
  far_site_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !data_we_i && wdata_i[17]) |=> $stable(data_o));
  // R13
  direct_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> data_o == $past(wdata_i));
endmodule

// File: rtl/plat_sysctl_rd_mux.sv
module plat_sysctl_rd_mux
  import plat_sysctl_pkg::*;
#(
  parameter logic [DW-1:0] PROC_ID0 = 32'h0,
  parameter logic [DW-1:0] PROC_ID1 = 32'h0,
  parameter logic [DW-1:0] BOARD_ID = 32'h0
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [LOCK_W-1:0] lock_i,
  input  logic [DW-1:0]     flags_i,
  input  logic [DW-1:0]     cnt_i [NUM_CNT],
  input  logic [DW-1:0]     cfg_data_i,
  output logic [DW-1:0]     rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_BOARD_ID: rdata_o = BOARD_ID;
      OFS_PROC_ID0: rdata_o = PROC_ID0;
      OFS_PROC_ID1: rdata_o = PROC_ID1;
      OFS_LOCK:     rdata_o = {{(DW-LOCK_W){1'b0}}, lock_i};
      OFS_FLAGS:    rdata_o = flags_i;
      OFS_FLASH:    rdata_o = FLASH_WORD;
      OFS_LCD:      rdata_o = LCD_WORD;
      OFS_CFG_DATA: rdata_o = cfg_data_i;
      OFS_CFG_CTRL: rdata_o = '0;
      OFS_CFG_STAT: rdata_o = 32'd1;
      default:      rdata_o = '0;
    endcase
    for (int i = 0; i < NUM_OSC; i++)
      if (addr_i == OFS_OSC_BASE + AW'(4 * i)) rdata_o = OSC_WORDS[i];
    for (int i = 0; i < NUM_CNT; i++)
      if (addr_i == OFS_CNT_BASE + AW'(4 * i)) rdata_o = cnt_i[i];
  end
endmodule

// File: rtl/plat_sysctl.sv
module plat_sysctl
  import plat_sysctl_pkg::*;
#(
  parameter logic [DW-1:0] PROC_ID0 = 32'h0C00_0191,
  parameter logic [DW-1:0] PROC_ID1 = 32'hFF00_0000,
  parameter logic [DW-1:0] BOARD_ID = 32'h0178_0500
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tick24_i,
  input  logic          tick100_i,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  logic              wr_en, rd_en;
  logic [LOCK_W-1:0] lock_q;
  logic [DW-1:0]     flags_q;
  logic [DW-1:0]     cfg_data;
  logic [DW-1:0]     cnt [NUM_CNT];
  logic [NUM_CNT-1:0] ticks;
  logic [DW-1:0]     rd_data;

  assign wr_en = req_i && we_i;
  assign rd_en = req_i && !we_i;
  assign ticks = {tick100_i, tick24_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= '0;
      flags_q <= '0;
    end else if (wr_en) begin
      if (addr_i == OFS_LOCK)      lock_q  <= wdata_i[LOCK_W-1:0];
      if (addr_i == OFS_FLAGS)     flags_q <= wdata_i;
      if (addr_i == OFS_FLAGS_CLR) flags_q <= '0;
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    plat_sysctl_tick_cnt #(.W(DW)) i_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (ticks[g]),
      .cnt_o  (cnt[g])
    );
  end

  plat_sysctl_cfg_mbox i_mbox (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_we_i (wr_en && addr_i == OFS_CFG_DATA),
    .ctrl_we_i (wr_en && addr_i == OFS_CFG_CTRL),
    .wdata_i   (wdata_i),
    .data_o    (cfg_data)
  );

  plat_sysctl_rd_mux #(
    .PROC_ID0 (PROC_ID0),
    .PROC_ID1 (PROC_ID1),
    .BOARD_ID (BOARD_ID)
  ) i_rd_mux (
    .addr_i     (addr_i),
    .lock_i     (lock_q),
    .flags_i    (flags_q),
    .cnt_i      (cnt),
    .cfg_data_i (cfg_data),
    .rdata_o    (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_en;
      rdata_o  <= rd_en ? rd_data : '0;
    end
  end

  // R2
  rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> rvalid_o);
  // R2
  no_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> !rvalid_o);
  // R7
  flags_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i == OFS_FLAGS_CLR) |=> flags_q == '0);
  // R6
  lock_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i == OFS_LOCK) |=> lock_q == $past(wdata_i[LOCK_W-1:0]));
  // R9
  stat_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && addr_i == OFS_CFG_STAT) |=> rdata_o == 32'd1);
endmodule

// File: tb/test_plat_sysctl.sv
`timescale 1ns/1ps
module test_plat_sysctl;
  localparam logic [31:0] P0 = 32'h0C00_0191;
  localparam logic [31:0] P1 = 32'hFF00_0000;
  localparam logic [31:0] BID = 32'h0178_0500;

  typedef struct packed {
    logic [3:0]  rq;
    logic        we;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 64;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 1'b0, 8'h20, 32'h0, 32'h0},              // R1
    '{4'd1, 1'b0, 8'h30, 32'h0, 32'h0},
    '{4'd1, 1'b0, 8'hA0, 32'h0, 32'h0},
    '{4'd1, 1'b0, 8'h5C, 32'h0, 32'h0},
    '{4'd3, 1'b0, 8'h00, 32'h0, BID},                // R3
    '{4'd3, 1'b0, 8'h84, 32'h0, P0},
    '{4'd3, 1'b0, 8'h88, 32'h0, P1},
    '{4'd4, 1'b0, 8'h4C, 32'h0, 32'h0},              // R4
    '{4'd4, 1'b0, 8'h50, 32'h0, 32'h0000_1F00},
    '{4'd4, 1'b0, 8'h0C, 32'h0, 32'h0001_2C5C},
    '{4'd4, 1'b0, 8'h10, 32'h0, 32'h0000_2CC0},
    '{4'd4, 1'b0, 8'h14, 32'h0, 32'h0000_2C75},
    '{4'd4, 1'b0, 8'h18, 32'h0, 32'h0002_0211},
    '{4'd4, 1'b0, 8'h1C, 32'h0, 32'h0000_2C75},
    '{4'd4, 1'b1, 8'h50, 32'hFFFF_FFFF, 32'h0},
    '{4'd4, 1'b0, 8'h50, 32'h0, 32'h0000_1F00},
    '{4'd4, 1'b1, 8'h0C, 32'h0, 32'h0},
    '{4'd4, 1'b0, 8'h0C, 32'h0, 32'h0001_2C5C},
    '{4'd5, 1'b0, 8'hD4, 32'h0, 32'h0},              // R5
    '{4'd5, 1'b0, 8'h40, 32'h0, 32'h0},
    '{4'd5, 1'b0, 8'h21, 32'h0, 32'h0},
    '{4'd6, 1'b1, 8'h20, 32'hDEAD_BEEF, 32'h0},      // R6
    '{4'd6, 1'b0, 8'h20, 32'h0, 32'h0000_BEEF},
    '{4'd7, 1'b1, 8'h30, 32'hA5A5_0F0F, 32'h0},      // R7
    '{4'd7, 1'b0, 8'h30, 32'h0, 32'hA5A5_0F0F},
    '{4'd5, 1'b1, 8'h40, 32'hFFFF_FFFF, 32'h0},
    '{4'd5, 1'b0, 8'h30, 32'h0, 32'hA5A5_0F0F},
    '{4'd5, 1'b0, 8'h20, 32'h0, 32'h0000_BEEF},
    '{4'd7, 1'b1, 8'h34, 32'hFFFF_FFFF, 32'h0},
    '{4'd7, 1'b0, 8'h30, 32'h0, 32'h0},
    '{4'd9, 1'b0, 8'hA8, 32'h0, 32'h1},              // R9
    '{4'd9, 1'b0, 8'hA4, 32'h0, 32'h0},
    '{4'd9, 1'b1, 8'hA8, 32'h0, 32'h0},
    '{4'd9, 1'b0, 8'hA8, 32'h0, 32'h1},
    '{4'd13, 1'b1, 8'hA0, 32'hCAFE_F00D, 32'h0},     // R13
    '{4'd13, 1'b0, 8'hA0, 32'h0, 32'hCAFE_F00D},
    '{4'd12, 1'b1, 8'hA4, 32'h8010_0000, 32'h0},     // R12
    '{4'd12, 1'b0, 8'hA0, 32'h0, 32'd25_000_000},
    '{4'd12, 1'b1, 8'hA4, 32'h8010_0002, 32'h0},
    '{4'd12, 1'b0, 8'hA0, 32'h0, 32'd24_000_000},
    '{4'd12, 1'b1, 8'hA4, 32'h8011_0000, 32'h0},
    '{4'd12, 1'b0, 8'hA0, 32'h0, 32'd50_000_000},
    '{4'd12, 1'b1, 8'hA4, 32'h8011_0004, 32'h0},
    '{4'd12, 1'b0, 8'hA0, 32'h0, 32'd40_000_000},
    '{4'd12, 1'b1, 8'hA4, 32'h8011_0006, 32'h0},
    '{4'd12, 1'b0, 8'hA0, 32'h0, 32'd35_000_000},
    '{4'd12, 1'b1, 8'hA4, 32'h8011_0008, 32'h0},
    '{4'd12, 1'b0, 8'hA0, 32'h0, 32'd40_000_000},
    '{4'd13, 1'b1, 8'hA0, 32'h1111_1111, 32'h0},
    '{4'd10, 1'b1, 8'hA4, 32'h0010_0000, 32'h0},     // R10 no start
    '{4'd10, 1'b0, 8'hA0, 32'h0, 32'h1111_1111},
    '{4'd10, 1'b1, 8'hA4, 32'hC010_0000, 32'h0},     // R10 write flag
    '{4'd10, 1'b0, 8'hA0, 32'h0, 32'h1111_1111},
    '{4'd11, 1'b1, 8'hA4, 32'h8410_0000, 32'h0},     // R11 controller 1
    '{4'd11, 1'b0, 8'hA0, 32'h0, 32'h1111_1111},
    '{4'd11, 1'b1, 8'hA4, 32'h8020_0000, 32'h0},     // R11 function 2
    '{4'd11, 1'b0, 8'hA0, 32'h0, 32'h1111_1111},
    '{4'd12, 1'b1, 8'hA4, 32'h8012_0000, 32'h0},     // R12 site 2
    '{4'd12, 1'b0, 8'hA0, 32'h0, 32'h1111_1111},
    '{4'd12, 1'b1, 8'hA4, 32'h8010_0003, 32'h0},     // R12 unknown dev
    '{4'd12, 1'b0, 8'hA0, 32'h0, 32'h0},
    '{4'd13, 1'b1, 8'hA0, 32'h1111_1111, 32'h0},
    '{4'd12, 1'b1, 8'hA4, 32'h8011_0001, 32'h0},
    '{4'd12, 1'b0, 8'hA0, 32'h0, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, t24 = 1'b0, t100 = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rvalid;
  logic [31:0] rdata;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  plat_sysctl #(.PROC_ID0(P0), .PROC_ID1(P1), .BOARD_ID(BID)) i_plat_sysctl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .tick24_i(t24), .tick100_i(t100),
    .rvalid_o(rvalid), .rdata_o(rdata)
  );

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                        output logic v, output logic [31:0] r);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    v = rvalid; r = rdata;
  endtask

  task automatic rd_chk(input int rq, input logic [7:0] a, input logic [31:0] exp);
    logic v;
    logic [31:0] r;
    access(1'b0, a, 32'h0, v, r);
    chk(2, {31'b0, v}, 32'h1);
    chk(rq, r, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic v;
    logic [31:0] r;
    access(1'b1, a, d, v, r);
    chk(2, {31'b0, v}, 32'h0);   // R2: no strobe on writes
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(1, {31'b0, rvalid}, 32'h0);  // R1: strobe low in reset
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
      else           rd_chk(int'(VEC[i].rq), VEC[i].addr, VEC[i].exp);
    end

    // R11: nonzero position is not served
    wr(8'hA0, 32'h2222_2222);
    wr(8'hA4, 32'h8010_1000);
    rd_chk(11, 8'hA0, 32'h2222_2222);

    // R2: strobe drops on the idle cycle after a read
    rd_chk(2, 8'h50, 32'h0000_1F00);
    @(negedge clk);
    chk(2, {31'b0, rvalid}, 32'h0);

    // R8: 37 ticks at 24 MHz, 100 ticks at 100 MHz
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      t100 = 1'b1;
      t24 = (i < 37);
    end
    @(negedge clk);
    t100 = 1'b0; t24 = 1'b0;
    rd_chk(8, 8'h5C, 32'd37);
    rd_chk(8, 8'h60, 32'd100);
    // R8: no advance without ticks
    repeat (5) @(negedge clk);
    rd_chk(8, 8'h60, 32'd100);

    // R1: reset in the middle of a run clears state
    wr(8'h30, 32'hFFFF_0000);
    wr(8'h20, 32'h0000_1234);
    wr(8'hA0, 32'h0BAD_F00D);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_chk(1, 8'h30, 32'h0);
    rd_chk(1, 8'h20, 32'h0);
    rd_chk(1, 8'hA0, 32'h0);
    rd_chk(1, 8'h5C, 32'h0);
    rd_chk(1, 8'h60, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule